// File: doc/BRIEF.md
# Clock source switch controller

This block holds the control and status word that selects the system clock among eight oscillator sources. It also runs the small sequencer that moves the clock from one source to another. Software picks a target source code and raises the switch-request bit in the same write. The block then checks the write protection and the lock rules, and refuses any direct move between the two PLL-based sources. If the request stands, it waits for the target oscillator's ready input, and also for PLL lock when the target runs through the PLL. It then takes the target as the active source and drops the request bit by itself.

Every control write must be preceded by a two-word key sequence on a separate key port. A clock-lock bit freezes the source selection, but only while the configuration input that honours the lock is high. A hardware clock-fail event sets a sticky flag, and software can clear that flag but never set it. Only the power-on reset input returns the word to its initial state. The source codes, in order 0 to 7, are: fast RC; fast RC divided by N through the PLL; primary; primary through the PLL; secondary; low-power RC; fast RC divided by 16; fast RC divided by N.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After power-on reset, both the active-source field (bits 14:12) and the requested-source field (bits 10:8) equal `cfg_init_src`. Every other read bit is 0, except bit 5, which follows `pll_locked`. `clk_sel` equals `cfg_init_src`.
- R2: Bits 15, 11, 4 and 2 of `bus_rdata` always read 0. Bit 5 always shows the present level of `pll_locked`, and no write can change it.
- R3: A control write (`bus_sel`=1) changes the word only if key 16'h5A3C was written on the key port (`bus_sel`=0) and 16'hC35A was written on the very next cycle. The control write must then come within `UNLOCK_WIN` cycles (default 4) after the second key. One accepted write uses up the unlock. Any other control write leaves the word unchanged.
- R4: While clock-lock (bit 7) is 1 and `cfg_lock_honor` is 1, an accepted write leaves bits 10:8 and bit 7 unchanged, and a switch request is dropped at once. Bits 6, 3 and 1 stay writable.
- R5: While `cfg_lock_honor` is 0, writes to bits 10:8 and 7 and switch requests act normally even if clock-lock is 1.
- R6: A request from active code 3 to code 1, or from code 1 to code 3, is refused. The switch bit (bit 0) reads 0 right after the write and the active source stays the same. The requested field still takes the written code.
- R7: An accepted request holds bit 0 at 1 until `src_ready[target]` is 1, and also `pll_locked` is 1 when the target is code 1 or code 3. On the first clock edge where this holds, the active field and `clk_sel` take the target and bit 0 returns to 0.
- R8: Clock-fail (bit 3) is set by `fail_detect`. An accepted write of 0 to bit 3 clears it. Writing 1 to bit 3 never sets it. If both happen at once, the set wins.
- R9: While a switch is pending, accepted writes leave bits 10:8 and bit 0 unchanged.
- R10: An accepted write stores bits 6 (I/O lock) and 1 (secondary enable) as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| cfg_init_src | input | 3 | Power-on source code from configuration |
| cfg_lock_honor | input | 1 | Configuration: 1 makes the clock-lock bit effective |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | 0 = key port, 1 = control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Control/status word |
| pll_locked | input | 1 | PLL lock or start-up timer expired |
| src_ready | input | 8 | Per-source oscillator ready, indexed by code |
| fail_detect | input | 1 | Clock-fail event from the monitor |
| clk_sel | output | 3 | Active source code for the clock mux |

## Verification
The assertions assume that `cfg_init_src` stays constant. They also assume that power-on reset is held for at least one clock before the first checked edge, so every `$past` term sees reset values. The bench asserts reset for several cycles and changes the configuration inputs only between bus writes. It never changes `cfg_init_src` at all. It drives all inputs on the falling edge, and a behavioural model checks every cycle alongside the directed checks.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int SRC_W   = 3;
    localparam int SRC_N   = 1 << SRC_W;
    localparam int WORD_W  = 16;

    localparam logic [WORD_W-1:0] KEY_FIRST  = 16'h5A3C;
    localparam logic [WORD_W-1:0] KEY_SECOND = 16'hC35A;

    localparam int B_SW_EN   = 0;
    localparam int B_SEC_EN  = 1;
    localparam int B_FAIL    = 3;
    localparam int B_PLL_OK  = 5;
    localparam int B_IO_LOCK = 6;
    localparam int B_CK_LOCK = 7;
    localparam int B_REQ_LO  = 8;
    localparam int B_CUR_LO  = 12;

    typedef enum logic [SRC_W-1:0] {
        SRC_FRC        = 3'd0,
        SRC_FRCN_PLL   = 3'd1,
        SRC_PRI        = 3'd2,
        SRC_PRI_PLL    = 3'd3,
        SRC_SEC        = 3'd4,
        SRC_LPRC       = 3'd5,
        SRC_FRC_DIV16  = 3'd6,
        SRC_FRCN       = 3'd7
    } clk_src_e;

    typedef struct packed {
        clk_src_e req;
        logic     ck_lock;
        logic     io_lock;
        logic     fail_keep;
        logic     sec_en;
        logic     sw_en;
    } ctrl_wr_t;

    function automatic logic uses_pll(clk_src_e s);
        return (s == SRC_FRCN_PLL) || (s == SRC_PRI_PLL);
    endfunction

    function automatic logic pll_hop(clk_src_e from_s, clk_src_e to_s);
        return uses_pll(from_s) && uses_pll(to_s) && (from_s != to_s);
    endfunction

    function automatic ctrl_wr_t unpack_wr(logic [WORD_W-1:0] d);
        ctrl_wr_t w;
        w.req       = clk_src_e'(d[B_REQ_LO +: SRC_W]);
        w.ck_lock   = d[B_CK_LOCK];
        w.io_lock   = d[B_IO_LOCK];
        w.fail_keep = d[B_FAIL];
        w.sec_en    = d[B_SEC_EN];
        w.sw_en     = d[B_SW_EN];
        return w;
    endfunction

endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock
    import clksw_pkg::*;
#(
    parameter int UNLOCK_WIN = 4
) (
    input  logic              clk,
    input  logic              por,
    input  logic              key_wr,
    input  logic [WORD_W-1:0] key_data,
    input  logic              ctrl_wr,
    output logic              ctrl_accept
);
    localparam int CNT_W = $clog2(UNLOCK_WIN + 1);

    logic             saw_first;
    logic [CNT_W-1:0] win_cnt;
    logic             key_done;

    assign key_done    = key_wr && (key_data == KEY_SECOND) && saw_first;
    assign ctrl_accept = ctrl_wr && (win_cnt != '0);

    always_ff @(posedge clk) begin
        if (por) begin
            saw_first <= 1'b0;
            win_cnt   <= '0;
        end else begin
            saw_first <= key_wr && (key_data == KEY_FIRST);
            if (key_done)
                win_cnt <= CNT_W'(UNLOCK_WIN);
            else if (ctrl_accept)
                win_cnt <= '0;
            else if (win_cnt != '0)
                win_cnt <= win_cnt - 1'b1;
        end
    end

    // R3: a window only opens right after the second key word
    assert_window_opens_on_key_R3: assert property (@(posedge clk) disable iff (por)
        ((win_cnt != '0) && ($past(win_cnt) == '0)) |-> $past(key_wr && (key_data == KEY_SECOND)));

    // R3: the window never outlasts its length
    assert_window_bounded_R3: assert property (@(posedge clk) disable iff (por)
        (win_cnt <= CNT_W'(UNLOCK_WIN)));

endmodule

// File: rtl/clksw_switch.sv
module clksw_switch
    import clksw_pkg::*;
#(
    parameter int N_SRC = SRC_N
) (
    input  logic             clk,
    input  logic             por,
    input  clk_src_e         init_src,
    input  logic             start,
    input  clk_src_e         target,
    input  logic             pll_locked,
    input  logic [N_SRC-1:0] src_ready,
    output logic             busy,
    output clk_src_e         cur_src
);
    typedef enum logic {SW_IDLE, SW_WAIT} sw_state_e;

    sw_state_e state;
    clk_src_e  tgt;
    logic      ready_ok;

    assign ready_ok = src_ready[tgt] && (!uses_pll(tgt) || pll_locked);
    assign busy     = (state == SW_WAIT);

    always_ff @(posedge clk) begin
        if (por) begin
            state   <= SW_IDLE;
            tgt     <= init_src;
            cur_src <= init_src;
        end else begin
            case (state)
                SW_IDLE: if (start) begin
                    state <= SW_WAIT;
                    tgt   <= target;
                end
                SW_WAIT: if (ready_ok) begin
                    cur_src <= tgt;
                    state   <= SW_IDLE;
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    // R6: a pending switch is never a direct PLL-to-PLL move
    assert_no_pll_hop_R6: assert property (@(posedge clk) disable iff (por)
        busy |-> !pll_hop(cur_src, tgt));

    // R7: the active source only moves at the end of a pending switch
    assert_cur_moves_on_ready_R7: assert property (@(posedge clk) disable iff (por)
        !$stable(cur_src) |-> ($past(busy) && $past(src_ready[tgt])));

    // R7: a PLL target completes only with lock present
    assert_pll_target_locked_R7: assert property (@(posedge clk) disable iff (por)
        ($fell(busy) && uses_pll(cur_src)) |-> $past(pll_locked));

endmodule

// File: rtl/clksw_fields.sv
module clksw_fields
    import clksw_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  clk_src_e init_src,
    input  logic     accept,
    input  ctrl_wr_t wr,
    input  logic     lock_honor,
    input  logic     busy,
    input  logic     fail_detect,
    output clk_src_e req_src,
    output logic     ck_lock,
    output logic     io_lock,
    output logic     sec_en,
    output logic     fail_flag,
    output logic     frozen
);
    assign frozen = ck_lock && lock_honor;

    always_ff @(posedge clk) begin
        if (por) begin
            req_src   <= init_src;
            ck_lock   <= 1'b0;
            io_lock   <= 1'b0;
            sec_en    <= 1'b0;
            fail_flag <= 1'b0;
        end else begin
            if (accept) begin
                if (!frozen && !busy)
                    req_src <= wr.req;
                if (!frozen)
                    ck_lock <= wr.ck_lock;
                io_lock <= wr.io_lock;
                sec_en  <= wr.sec_en;
            end
            if (fail_detect)
                fail_flag <= 1'b1;
            else if (accept && !wr.fail_keep)
                fail_flag <= 1'b0;
        end
    end

    // R4: an honoured lock freezes the selection and the lock bit
    assert_lock_freezes_sel_R4: assert property (@(posedge clk) disable iff (por)
        $past(frozen) |-> ($stable(req_src) && $stable(ck_lock)));

    // R9: the requested field holds while a switch is pending
    assert_req_held_busy_R9: assert property (@(posedge clk) disable iff (por)
        $past(busy) |-> $stable(req_src));

    // R8: software cannot raise the clock-fail flag
    assert_fail_set_by_hw_R8: assert property (@(posedge clk) disable iff (por)
        $rose(fail_flag) |-> $past(fail_detect));

    // R3: fields change only through an accepted write
    assert_fields_need_accept_R3: assert property (@(posedge clk) disable iff (por)
        !$past(accept) |-> ($stable(io_lock) && $stable(sec_en) && $stable(ck_lock)));

endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
    import clksw_pkg::*;
#(
    parameter int UNLOCK_WIN = 4
) (
    input  logic              clk,
    input  logic              por,
    input  logic [SRC_W-1:0]  cfg_init_src,
    input  logic              cfg_lock_honor,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              pll_locked,
    input  logic [SRC_N-1:0]  src_ready,
    input  logic              fail_detect,
    output logic [SRC_W-1:0]  clk_sel
);
    clk_src_e init_src;
    clk_src_e cur_src;
    clk_src_e req_src;
    ctrl_wr_t wr;
    logic     accept, busy, start, frozen;
    logic     ck_lock, io_lock, sec_en, fail_flag;

    assign init_src = clk_src_e'(cfg_init_src);
    assign wr       = unpack_wr(bus_wdata);

    clksw_unlock #(.UNLOCK_WIN(UNLOCK_WIN)) u_unlock (
        .clk         (clk),
        .por         (por),
        .key_wr      (bus_wr && !bus_sel),
        .key_data    (bus_wdata),
        .ctrl_wr     (bus_wr && bus_sel),
        .ctrl_accept (accept)
    );

    clksw_fields u_fields (
        .clk         (clk),
        .por         (por),
        .init_src    (init_src),
        .accept      (accept),
        .wr          (wr),
        .lock_honor  (cfg_lock_honor),
        .busy        (busy),
        .fail_detect (fail_detect),
        .req_src     (req_src),
        .ck_lock     (ck_lock),
        .io_lock     (io_lock),
        .sec_en      (sec_en),
        .fail_flag   (fail_flag),
        .frozen      (frozen)
    );

    assign start = accept && wr.sw_en && !busy && !frozen && !pll_hop(cur_src, wr.req);

    clksw_switch #(.N_SRC(SRC_N)) u_switch (
        .clk        (clk),
        .por        (por),
        .init_src   (init_src),
        .start      (start),
        .target     (wr.req),
        .pll_locked (pll_locked),
        .src_ready  (src_ready),
        .busy       (busy),
        .cur_src    (cur_src)
    );

    always_comb begin
        bus_rdata                       = '0;
        bus_rdata[B_CUR_LO +: SRC_W]    = cur_src;
        bus_rdata[B_REQ_LO +: SRC_W]    = req_src;
        bus_rdata[B_CK_LOCK]            = ck_lock;
        bus_rdata[B_IO_LOCK]            = io_lock;
        bus_rdata[B_PLL_OK]             = pll_locked;
        bus_rdata[B_FAIL]               = fail_flag;
        bus_rdata[B_SEC_EN]             = sec_en;
        bus_rdata[B_SW_EN]              = busy;
    end

    assign clk_sel = cur_src;

    // R2: reserved bits never read as 1
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (por)
        (bus_rdata[15] == 1'b0) && (bus_rdata[11] == 1'b0) && (bus_rdata[4] == 1'b0) && (bus_rdata[2] == 1'b0));

    // R6: a refused PLL hop never leaves the switch bit set
    assert_hop_refused_R6: assert property (@(posedge clk) disable iff (por)
        ($past(accept && wr.sw_en && !busy) && pll_hop($past(cur_src), $past(wr.req))) |-> !busy);

endmodule

// File: tb/clk_switch_ctrl_test.sv
module clk_switch_ctrl_test;
    localparam int WIN = 4;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic [2:0]  cfg_init_src = 3'd2;
    logic        cfg_lock_honor = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pll_locked = 1'b0;
    logic [7:0]  src_ready = 8'hFF;
    logic        fail_detect = 1'b0;
    logic [2:0]  clk_sel;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string phase = "R1";

    clk_switch_ctrl #(.UNLOCK_WIN(WIN)) uut (
        .clk(clk), .por(por), .cfg_init_src(cfg_init_src), .cfg_lock_honor(cfg_lock_honor),
        .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_locked(pll_locked), .src_ready(src_ready), .fail_detect(fail_detect),
        .clk_sel(clk_sel)
    );

    always #5 clk = ~clk;

    // behavioural reference state
    logic [2:0] m_cur, m_req;
    bit m_lock, m_io, m_sec, m_cf, m_sw, m_saw;
    int m_win;

    function automatic bit is_pll(logic [2:0] c);
        return (c == 3'd1) || (c == 3'd3);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit acc, key2, o_sw, o_frz;
        logic [2:0] o_cur, nreq;
        cyc++;
        if (por) begin
            m_cur = cfg_init_src; m_req = cfg_init_src;
            m_lock = 0; m_io = 0; m_sec = 0; m_cf = 0; m_sw = 0; m_saw = 0; m_win = 0;
        end else begin
            acc   = bus_wr && bus_sel && (m_win > 0);
            key2  = bus_wr && !bus_sel && (bus_wdata == 16'hC35A) && m_saw;
            o_sw  = m_sw;
            o_frz = m_lock && cfg_lock_honor;
            o_cur = m_cur;
            nreq  = bus_wdata[10:8];
            if (o_sw && src_ready[m_req] && (!is_pll(m_req) || pll_locked)) begin
                m_cur = m_req; m_sw = 0;
            end
            if (acc) begin
                if (!o_frz && !o_sw) m_req = nreq;
                if (!o_frz) m_lock = bus_wdata[7];
                m_io  = bus_wdata[6];
                m_sec = bus_wdata[1];
                if (!bus_wdata[3]) m_cf = 0;
                if (bus_wdata[0] && !o_sw && !o_frz && !(is_pll(o_cur) && is_pll(nreq) && o_cur != nreq))
                    m_sw = 1;
            end
            if (fail_detect) m_cf = 1;
            m_saw = bus_wr && !bus_sel && (bus_wdata == 16'h5A3C);
            if (key2) m_win = WIN;
            else if (acc) m_win = 0;
            else if (m_win > 0) m_win--;
        end
        #3;
        if (!por) begin
            chk({phase, " model"}, bus_rdata,
                {1'b0, m_cur, 1'b0, m_req, m_lock, m_io, pll_locked, 1'b0, m_cf, 1'b0, m_sec, m_sw});
            chk({phase, " clk_sel"}, {13'd0, clk_sel}, {13'd0, m_cur});
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic bus(bit sel, logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
        end
    endtask

    task automatic uwrite(logic [15:0] d);
        bus(0, 16'h5A3C); bus(0, 16'hC35A); bus(1, d); quiet(1);
    endtask

    initial begin
        quiet(4);
        @(negedge clk); por = 1'b0;
        quiet(1);
        phase = "R1";
        chk("R1 reset word", bus_rdata, 16'h2200);
        chk("R1 clk_sel", {13'd0, clk_sel}, 16'd2);

        phase = "R2";
        pll_locked = 1'b1; #1;
        chk("R2 pll bit", bus_rdata, 16'h2220);
        pll_locked = 1'b0;
        quiet(1);

        phase = "R3";
        bus(1, 16'h07C3); quiet(1);
        chk("R3 no keys", bus_rdata, 16'h2200);
        bus(0, 16'hC35A); bus(0, 16'h5A3C); bus(1, 16'h07C3); quiet(1);
        chk("R3 keys swapped", bus_rdata, 16'h2200);
        bus(0, 16'h5A3C); quiet(1); bus(0, 16'hC35A); bus(1, 16'h07C3); quiet(1);
        chk("R3 keys apart", bus_rdata, 16'h2200);
        bus(0, 16'h5A3C); bus(0, 16'hC35A); quiet(WIN); bus(1, 16'h07C3); quiet(1);
        chk("R3 window expired", bus_rdata, 16'h2200);
        bus(0, 16'h5A3C); bus(0, 16'hC35A); quiet(1); bus(1, 16'h0242); quiet(1);
        phase = "R10";
        chk("R10 io and sec stored", bus_rdata, 16'h2242);
        phase = "R3";
        bus(1, 16'h0200); quiet(1);
        chk("R3 unlock consumed", bus_rdata, 16'h2242);

        phase = "R7";
        src_ready = 8'hFE;
        uwrite(16'h0001);
        chk("R7 pending", bus_rdata, 16'h2001);
        quiet(3);
        chk("R7 waits ready", bus_rdata, 16'h2001);
        phase = "R9";
        uwrite(16'h0500);
        chk("R9 busy ignores req", bus_rdata, 16'h2001);
        phase = "R7";
        src_ready = 8'hFF;
        quiet(1);
        chk("R7 complete", bus_rdata, 16'h0000);
        chk("R7 clk_sel", {13'd0, clk_sel}, 16'd0);

        uwrite(16'h0301);
        quiet(3);
        chk("R7 waits pll lock", bus_rdata, 16'h0301);
        pll_locked = 1'b1;
        quiet(1);
        chk("R7 pll target done", bus_rdata, 16'h3320);

        phase = "R6";
        uwrite(16'h0101);
        chk("R6 hop 3 to 1 refused", bus_rdata, 16'h3120);
        uwrite(16'h0001); quiet(1);
        chk("R6 via 0", bus_rdata, 16'h0020);
        uwrite(16'h0101); quiet(1);
        chk("R6 0 to 1", bus_rdata, 16'h1120);
        uwrite(16'h0301);
        chk("R6 hop 1 to 3 refused", bus_rdata, 16'h1320);

        phase = "R4";
        uwrite(16'h0380);
        chk("R4 lock set", bus_rdata, 16'h13A0);
        uwrite(16'h0001); quiet(1);
        chk("R4 frozen", bus_rdata, 16'h13A0);
        uwrite(16'h0041);
        chk("R4 io still writable", bus_rdata, 16'h13E0);

        phase = "R5";
        cfg_lock_honor = 1'b0;
        uwrite(16'h0081);
        chk("R5 switch allowed", bus_rdata, 16'h10A1);
        quiet(1);
        chk("R5 switch done", bus_rdata, 16'h00A0);
        uwrite(16'h0000);
        chk("R5 lock cleared", bus_rdata, 16'h0020);
        cfg_lock_honor = 1'b1;

        phase = "R8";
        @(negedge clk); fail_detect = 1'b1;
        @(negedge clk); fail_detect = 1'b0;
        chk("R8 fail set", bus_rdata, 16'h0028);
        bus(1, 16'h0000); quiet(1);
        chk("R8 locked write no clear", bus_rdata, 16'h0028);
        uwrite(16'h0008);
        chk("R8 write 1 keeps", bus_rdata, 16'h0028);
        uwrite(16'h0000);
        chk("R8 write 0 clears", bus_rdata, 16'h0020);
        uwrite(16'h0008);
        chk("R8 write 1 no set", bus_rdata, 16'h0020);

        quiet(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule